// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides one input clock by an integer that software selects through a field of a 32-bit control register. A write port loads the register and a read port returns what it holds. The field is found by a mask and a shift. One of five encodings, chosen at elaboration, turns the field into a divisor: value plus one, value as is, two to the power of the value, value as is with zero also meaning one, or a short lookup list of key/divisor pairs. The result is then clamped to a configured range.

The output clock is never gated. For divisors of two or more it comes from a registered counter, high for the lower half of each period. Divide-by-one routes the input clock straight through to the output. A new divisor is taken only when the current output period completes, so a reprogramming never shortens a pulse. A field value that the chosen encoding cannot give a meaning to selects divide-by-one and raises a status output. An optional write mode treats the upper 16 bits of each write as per-bit enables for the lower 16 bits.

Top module: `clk_div_reg`

## Requirements
- R1: With the plus-one encoding, field value f divides the clock by f+1. The bench instance uses mask 0x3F with the shift at bit 0.
- R2: With the value-as-is encoding, field value f (f >= 1) divides by f. A field of 0 divides by 1 and drives bad_div_o high. bad_div_o is low for every valid field.
- R3: With the power-of-two encoding, field value f divides by 2^f.
- R4: With the zero-allowed encoding, field values 0 and 1 both divide by 1 and bad_div_o stays low. Any other f divides by f.
- R5: With the lookup encoding, a field equal to a listed key divides by that key's divisor. In the default list, key 0 gives 4 and key 1 gives 8. Any other field divides by 1 and drives bad_div_o high.
- R6: The field is (register AND mask) shifted right by the shift. When the shift parameter is negative, the shift is the index of the lowest set bit of the mask. Register bits outside the mask do not change the divisor.
- R7: A valid divisor above MAX_DIV is replaced by MAX_DIV, and one below MIN_DIV is replaced by MIN_DIV. An invalid field still gives divide-by-1.
- R8: In half-word-enable mode, bit i+16 of a write enables bit i of the 16-bit register. A bit whose enable is 0 keeps its value, and bits 31:16 read back as 0.
- R9: In normal mode, a write loads all 32 bits, and rd_data_o shows them from the clock edge that takes the write.
- R10: For divisor N >= 2, clk_o is high for floor(N/2) input cycles and low for the remaining cycles of each N-cycle period.
- R11: For divisor 1, clk_o follows clk_i.
- R12: A new divisor takes effect only at the end of the output period in progress. The period in progress completes with its old high and low lengths.
- R13: Reset clears the register to 0, so the reset divisor is the decode of field 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock, the one that is divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 32 | Write data (upper half used as bit enables in half-word-enable mode) |
| rd_data_o | output | 32 | Current control register contents |
| clk_o | output | 1 | Divided output clock |
| bad_div_o | output | 1 | Field value has no meaning in the chosen encoding |

## Verification
A write is visible on rd_data_o and bad_div_o one clock edge after the cycle in which it is driven. The bench checks both at the next falling edge. A new divisor reaches clk_o only after the old period completes, which can take up to MAX_DIV cycles. The bench therefore waits 150 cycles after each write and then measures one full period by sampling clk_o at falling edges, where the registered output is stable. The period-boundary test instead records the eleven falling-edge samples that follow a write made on the first high cycle of a divide-by-8 period, and compares them with the sequence expected from the old period followed by the new one. Divide-by-1 is checked 2 ns after each rising and each falling edge, because there clk_o must copy clk_i.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  typedef enum logic [2:0] {
    ENC_MINUS_ONE,
    ENC_ONE_BASED,
    ENC_POW2,
    ENC_ALLOW_ZERO,
    ENC_TABLE
  } enc_e;

  function automatic int low_bit(logic [31:0] m);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl #(
  parameter bit HIWORD = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] ctrl_o
);
  generate
    if (HIWORD) begin : g_hw
      logic [15:0] lo_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lo_q <= '0;
        else if (wr_en_i)
          lo_q <= (wr_data_i[31:16] & wr_data_i[15:0]) | (~wr_data_i[31:16] & lo_q);
      end
      assign ctrl_o = {16'h0000, lo_q};
    end else begin : g_full
      logic [31:0] reg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) reg_q <= '0;
        else if (wr_en_i) reg_q <= wr_data_i;
      end
      assign ctrl_o = reg_q;
    end
  endgenerate
endmodule

// File: rtl/clk_div_decode.sv
module clk_div_decode
  import clk_div_pkg::*;
#(
  parameter enc_e        ENC        = ENC_MINUS_ONE,
  parameter logic [31:0] FIELD_MASK = 32'h0000_003F,
  parameter int          FIELD_SHIFT = -1,
  parameter int          MIN_DIV    = 1,
  parameter int          MAX_DIV    = 64,
  parameter int          TBL_N      = 2,
  parameter logic [TBL_N-1:0][31:0] TBL_KEY = {32'd1, 32'd0},
  parameter logic [TBL_N-1:0][31:0] TBL_DIV = {32'd8, 32'd4},
  localparam int         DIV_W      = $clog2(MAX_DIV + 1)
) (
  input  logic [31:0]      ctrl_i,
  output logic [DIV_W-1:0] div_o,
  output logic             bad_o
);
  localparam int SHIFT = (FIELD_SHIFT < 0) ? low_bit(FIELD_MASK) : FIELD_SHIFT;

  logic [31:0] field;
  logic [32:0] raw;
  logic        invalid;

  assign field = (ctrl_i & FIELD_MASK) >> SHIFT;

  generate
    if (ENC == ENC_MINUS_ONE) begin : g_m1
      assign raw     = {1'b0, field} + 33'd1;
      assign invalid = 1'b0;
    end else if (ENC == ENC_ONE_BASED) begin : g_one
      assign raw     = {1'b0, field};
      assign invalid = (field == 32'd0);
    end else if (ENC == ENC_POW2) begin : g_p2
      // large exponents saturate; the clamp below limits them
      assign raw     = (field > 32'd31) ? 33'h1_0000_0000 : (33'd1 << field[4:0]);
      assign invalid = 1'b0;
    end else if (ENC == ENC_ALLOW_ZERO) begin : g_az
      assign raw     = (field == 32'd0) ? 33'd1 : {1'b0, field};
      assign invalid = 1'b0;
    end else begin : g_tbl
      logic        hit;
      logic [32:0] traw;
      always_comb begin
        hit  = 1'b0;
        traw = 33'd1;
        for (int i = 0; i < TBL_N; i++) begin
          if (!hit && field == TBL_KEY[i]) begin
            hit  = 1'b1;
            traw = {1'b0, TBL_DIV[i]};
          end
        end
      end
      assign raw     = traw;
      assign invalid = !hit;
    end
  endgenerate

  always_comb begin
    if (invalid)                    div_o = DIV_W'(1);
    else if (raw > 33'(MAX_DIV))    div_o = DIV_W'(MAX_DIV);
    else if (raw < 33'(MIN_DIV))    div_o = DIV_W'(MIN_DIV);
    else                            div_o = raw[DIV_W-1:0];
  end

  assign bad_o = invalid;
endmodule

// File: rtl/clk_div_gen.sv
module clk_div_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] next_div_i,
  output logic             clk_o,
  output logic [DIV_W-1:0] cur_div_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q, cur_q, hi_len;
  logic             out_q, wrap;

  assign wrap   = (cnt_q == cur_q - DIV_W'(1));
  assign hi_len = cur_q >> 1;

  // divisor is only reloaded on the last cycle of a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= DIV_W'(1);
      out_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      cur_q <= next_div_i;
      out_q <= (next_div_i > DIV_W'(1));
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      out_q <= (cnt_q + DIV_W'(1)) < hi_len;
    end
  end

  assign clk_o     = (cur_q == DIV_W'(1)) ? clk_i : out_q;
  assign cur_div_o = cur_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/clk_div_reg.sv
module clk_div_reg
  import clk_div_pkg::*;
#(
  parameter enc_e        ENC         = ENC_MINUS_ONE,
  parameter logic [31:0] FIELD_MASK  = 32'h0000_003F,
  parameter int          FIELD_SHIFT = -1,
  parameter bit          HIWORD      = 1'b0,
  parameter int          MIN_DIV     = 1,
  parameter int          MAX_DIV     = 64,
  parameter int          TBL_N       = 2,
  parameter logic [TBL_N-1:0][31:0] TBL_KEY = {32'd1, 32'd0},
  parameter logic [TBL_N-1:0][31:0] TBL_DIV = {32'd8, 32'd4},
  localparam int         DIV_W       = $clog2(MAX_DIV + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        clk_o,
  output logic        bad_div_o
);
  logic [31:0]      ctrl;
  logic [DIV_W-1:0] next_div, cur_div, cnt;

  clk_div_ctrl #(.HIWORD(HIWORD)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .ctrl_o(ctrl)
  );

  clk_div_decode #(
    .ENC(ENC), .FIELD_MASK(FIELD_MASK), .FIELD_SHIFT(FIELD_SHIFT),
    .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
    .TBL_N(TBL_N), .TBL_KEY(TBL_KEY), .TBL_DIV(TBL_DIV)
  ) u_dec (
    .ctrl_i(ctrl), .div_o(next_div), .bad_o(bad_div_o)
  );

  clk_div_gen #(.DIV_W(DIV_W)) u_gen (
    .clk_i, .rst_ni, .next_div_i(next_div),
    .clk_o, .cur_div_o(cur_div), .cnt_o(cnt)
  );

  assign rd_data_o = ctrl;
endmodule

// File: rtl/clk_div_reg_chk.sv
module clk_div_reg_chk #(
  parameter bit HIWORD  = 1'b0,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 64,
  parameter int DIV_W   = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [31:0]      wr_data_i,
  input logic [31:0]      rd_data_o,
  input logic             bad_div_o,
  input logic [DIV_W-1:0] next_div,
  input logic [DIV_W-1:0] cur_div,
  input logic [DIV_W-1:0] cnt
);
  // R12
  div_swap_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_div != $past(cur_div)) |-> ($past(cnt) == $past(cur_div) - DIV_W'(1)));

  // R10
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < cur_div);

  // R2
  bad_forces_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_div_o |-> (next_div == DIV_W'(1)));

  // R7
  div_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_div_o |-> (next_div >= DIV_W'(MIN_DIV) && next_div <= DIV_W'(MAX_DIV)));

  generate
    if (HIWORD) begin : g_hw
      // R8
      masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (((rd_data_o[15:0] ^ $past(rd_data_o[15:0])) & ~$past(wr_data_i[31:16])) == 16'h0));
    end else begin : g_full
      // R9
      full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o == $past(wr_data_i)));
    end
  endgenerate
endmodule

bind clk_div_reg clk_div_reg_chk #(
  .HIWORD(HIWORD), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .bad_div_o(bad_div_o),
  .next_div(next_div), .cur_div(cur_div), .cnt(cnt)
);

// File: tb/clk_div_reg_tb.sv
`timescale 1ns/1ps
module clk_div_reg_tb;
  import clk_div_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  wr_en = '0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd [5];
  wire  [4:0]  co;
  wire  [4:0]  bad;
  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  // 0: plus-one, 1: as-is + half-word enables, 2: pow2 clamped, 3: zero-allowed, 4: lookup
  clk_div_reg #(.ENC(ENC_MINUS_ONE), .FIELD_MASK(32'h3F), .FIELD_SHIFT(0), .MAX_DIV(64)) u_dut (
    .clk_i, .rst_ni, .wr_en_i(wr_en[0]), .wr_data_i(wr_data),
    .rd_data_o(rd[0]), .clk_o(co[0]), .bad_div_o(bad[0]));
  clk_div_reg #(.ENC(ENC_ONE_BASED), .FIELD_MASK(32'hF0), .HIWORD(1'b1), .MAX_DIV(16)) u_dut_one (
    .clk_i, .rst_ni, .wr_en_i(wr_en[1]), .wr_data_i(wr_data),
    .rd_data_o(rd[1]), .clk_o(co[1]), .bad_div_o(bad[1]));
  clk_div_reg #(.ENC(ENC_POW2), .FIELD_MASK(32'h7), .MIN_DIV(2), .MAX_DIV(16)) u_dut_p2 (
    .clk_i, .rst_ni, .wr_en_i(wr_en[2]), .wr_data_i(wr_data),
    .rd_data_o(rd[2]), .clk_o(co[2]), .bad_div_o(bad[2]));
  clk_div_reg #(.ENC(ENC_ALLOW_ZERO), .FIELD_MASK(32'hF), .MAX_DIV(16)) u_dut_az (
    .clk_i, .rst_ni, .wr_en_i(wr_en[3]), .wr_data_i(wr_data),
    .rd_data_o(rd[3]), .clk_o(co[3]), .bad_div_o(bad[3]));
  clk_div_reg #(.ENC(ENC_TABLE), .FIELD_MASK(32'h3), .MAX_DIV(16)) u_dut_tbl (
    .clk_i, .rst_ni, .wr_en_i(wr_en[4]), .wr_data_i(wr_data),
    .rd_data_o(rd[4]), .clk_o(co[4]), .bad_div_o(bad[4]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk_i);
    wr_data = d;
    wr_en[idx] = 1'b1;
    @(negedge clk_i);
    wr_en = '0;
  endtask

  task automatic chk_pass(input int idx, input string req);
    int bad_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i); #2;
      if (co[idx] !== 1'b1) bad_cnt++;
      @(negedge clk_i); #2;
      if (co[idx] !== 1'b0) bad_cnt++;
    end
    chk(req, bad_cnt, 0);
  endtask

  task automatic chk_div(input int idx, input int n, input string req);
    int hi = 0;
    int lo = 0;
    logic prev;
    repeat (150) @(negedge clk_i);
    if (n == 1) begin
      chk_pass(idx, req);
      return;
    end
    prev = co[idx];
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (!prev && co[idx]) break;
      prev = co[idx];
    end
    while (co[idx] && hi < 300) begin hi++; @(negedge clk_i); end
    while (!co[idx] && lo < 300) begin lo++; @(negedge clk_i); end
    chk({req, " high"}, hi, n / 2);
    chk({req, " low"}, lo, n - n / 2);
  endtask

  task automatic test_reset;
    #3;
    for (int i = 0; i < 5; i++) chk("R13 reset readback", rd[i], 32'h0);
    chk("R13 reset status plus-one", bad[0], 1'b0);
    chk("R2 reset status as-is field 0", bad[1], 1'b1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_div(0, 1, "R13 R11 reset divide");
  endtask

  task automatic test_minus_one;
    wr(0, 32'h1);  chk_div(0, 2, "R1 R10 f=1");
    wr(0, 32'h2);  chk_div(0, 3, "R1 R10 f=2");
    wr(0, 32'h7);  chk_div(0, 8, "R1 R10 f=7");
    wr(0, 32'h3F); chk_div(0, 64, "R1 f=63");
    wr(0, 32'hABCD_0004);
    chk("R9 full readback", rd[0], 32'hABCD_0004);
    chk_div(0, 5, "R6 bits outside mask");
    wr(0, 32'h0);  chk_div(0, 1, "R11 f=0 passthrough");
  endtask

  task automatic test_change_at_wrap;
    logic [10:0] got;
    logic prev;
    wr(0, 32'h7);
    repeat (150) @(negedge clk_i);
    prev = co[0];
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (!prev && co[0]) break;
      prev = co[0];
    end
    wr_data = 32'h1;
    wr_en[0] = 1'b1;
    for (int i = 10; i >= 0; i--) begin
      @(negedge clk_i);
      wr_en = '0;
      got[i] = co[0];
    end
    chk("R12 old period completes then new", {21'h0, got}, {21'h0, 11'b111_0000_1010});
  endtask

  task automatic test_one_based_hiword;
    wr(1, 32'hFFFF_0050);
    chk("R8 masked write readback", rd[1], 32'h0000_0050);
    chk("R2 valid status", bad[1], 1'b0);
    chk_div(1, 5, "R2 R6 f=5 auto shift");
    wr(1, 32'h000F_003F);
    chk("R8 disabled bits keep", rd[1], 32'h0000_005F);
    chk_div(1, 5, "R8 field unchanged");
    wr(1, 32'h00F0_0000);
    chk("R2 f=0 status", bad[1], 1'b1);
    chk_div(1, 1, "R2 f=0 divide by 1");
    wr(1, 32'h00F0_0030);
    chk("R2 f=3 status", bad[1], 1'b0);
    chk_div(1, 3, "R2 f=3");
  endtask

  task automatic test_pow2;
    wr(2, 32'h2); chk_div(2, 4, "R3 f=2");
    wr(2, 32'h3); chk_div(2, 8, "R3 f=3");
    wr(2, 32'h5); chk_div(2, 16, "R7 clamp to max");
    wr(2, 32'h0); chk_div(2, 2, "R7 clamp to min");
    chk("R7 clamp status", bad[2], 1'b0);
  endtask

  task automatic test_allow_zero;
    wr(3, 32'h0);
    chk("R4 f=0 status", bad[3], 1'b0);
    chk_div(3, 1, "R4 f=0");
    wr(3, 32'h6); chk_div(3, 6, "R4 f=6");
    wr(3, 32'h1); chk_div(3, 1, "R4 f=1");
  endtask

  task automatic test_table;
    wr(4, 32'h0); chk_div(4, 4, "R5 key 0");
    wr(4, 32'h1); chk_div(4, 8, "R5 key 1");
    chk("R5 listed status", bad[4], 1'b0);
    wr(4, 32'h2);
    chk("R5 unlisted status", bad[4], 1'b1);
    chk_div(4, 1, "R5 unlisted divide by 1");
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_minus_one();
    test_change_at_wrap();
    test_one_based_hiword();
    test_pow2();
    test_allow_zero();
    test_table();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule